// File: doc/BRIEF.md
# Windowed Register Address Translator

This block lets a master reach a large internal register space through a small number of fixed-size apertures mapped into a local bus region. Every aperture keeps one base address, held internally in dword units. An access names an aperture and a full byte target. If the target lies inside that aperture, the block forwards the access at once. If it does not, the block first moves the aperture's base to the target, spending one extra cycle on the base-register write. The local bus address is the region start, plus the aperture index times the aperture size, plus the offset inside the aperture. A set-window operation moves a base without forwarding any access, and it writes nothing when the base already equals the target.

A second part manages ownership of the apertures. The lowest indices are reserved and can only be claimed directly by index. The other apertures sit in a free set. An allocate request takes the lowest free index. When none is free, the request retries on a fixed tick until a retry limit is reached and then reports failure. A release puts an index back into the free set.

Access machine states: IDLE (accept a request), CHECK (compare the target with the stored base), REBASE (write the base register), ISSUE (done and bus strobe). Its transitions are IDLE->CHECK on a request, CHECK->ISSUE on a hit or an unchanged set-window, CHECK->REBASE otherwise, REBASE->ISSUE, and ISSUE->IDLE. Allocation machine states: IDLE, TRY (look at the free set), WAIT (one tick of back-off), GRANT, FAIL. Its transitions are IDLE->TRY on a request, TRY->GRANT when an index is free, TRY->WAIT when none is free and attempts remain, TRY->FAIL on the last attempt, WAIT->TRY when the tick expires, and GRANT/FAIL->IDLE. The aperture size must be a power of two.

Top module: `aperture_xlate`

## Requirements
- R1: After reset, every aperture base is invalid (all ones in dword form), and the first access through any aperture causes a rebase.
- R2: An access hits when target >= byte base and target - byte base < WIN_BYTES. On a hit, acc_done_o rises one cycle after the cycle that follows the accepting edge, and no base write occurs.
- R3: On a miss, cfg_wr_o pulses for one cycle with cfg_idx_o set to the aperture and cfg_base_o set to target >> 2. The offset becomes 0, and acc_done_o follows one cycle later than on a hit.
- R4: bus_addr_o equals REGION_BASE + index * WIN_BYTES + offset.
- R5: For a normal access, bus_valid_o is a single-cycle strobe coincident with acc_done_o, carrying the requested write flag (1 = write) and write data.
- R6: A set-window operation (acc_setwin_i = 1) never raises bus_valid_o. It writes the base only when the target differs from the current byte base.
- R7: A reserved request with index < NUM_RSVD gives rsv_ok_o and rsv_win_o one cycle later. Any other index gives rsv_rej_o.
- R8: After reset, the free set holds indices NUM_RSVD..NUM_WIN-1. Allocation grants the lowest free index, one cycle after the accepting edge, and never grants a reserved index.
- R9: With no free index, allocation makes RETRY_MAX attempts spaced TICK_CYC+1 cycles apart. alloc_fail_o pulses (RETRY_MAX-1)*(TICK_CYC+1)+1 cycles after the accepting edge.
- R10: A release returns a non-reserved index to the free set, and a waiting allocation takes it at its next attempt. A release of a reserved index has no effect.
- R11: An invalidate pulse (inval_i) returns every base to the invalid value, so the next access through any aperture rebases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inval_i | input | 1 | Invalidate all aperture bases |
| acc_req_i | input | 1 | Access request, taken when idle |
| acc_setwin_i | input | 1 | 1 = set-window only, 0 = read/write access |
| acc_win_i | input | IDX_W | Aperture index |
| acc_addr_i | input | ADDR_W | Byte target address |
| acc_we_i | input | 1 | 1 = write, 0 = read |
| acc_wdata_i | input | 32 | Write data |
| acc_busy_o | output | 1 | Access machine not idle |
| acc_done_o | output | 1 | Access finished (one cycle) |
| bus_valid_o | output | 1 | Local bus strobe |
| bus_we_o | output | 1 | Local bus write flag |
| bus_addr_o | output | ADDR_W | Local bus address |
| bus_wdata_o | output | 32 | Local bus write data |
| cfg_wr_o | output | 1 | Base-register write strobe |
| cfg_idx_o | output | IDX_W | Aperture being rebased |
| cfg_base_o | output | ADDR_W | New base in dword units |
| rsv_req_i | input | 1 | Reserved-aperture request |
| rsv_idx_i | input | IDX_W | Requested reserved index |
| rsv_ok_o | output | 1 | Reserved request granted |
| rsv_rej_o | output | 1 | Reserved request rejected |
| rsv_win_o | output | IDX_W | Index of the answered request |
| alloc_req_i | input | 1 | Allocate request, taken when idle |
| alloc_busy_o | output | 1 | Allocation machine not idle |
| alloc_ok_o | output | 1 | Allocation granted (one cycle) |
| alloc_fail_o | output | 1 | Allocation failed (one cycle) |
| alloc_win_o | output | IDX_W | Granted index |
| rel_i | input | 1 | Release strobe |
| rel_idx_i | input | IDX_W | Index to release |

## Verification
The bench places targets at offset WIN_BYTES-1, at exactly WIN_BYTES, and one dword below the base. A design with an inclusive upper bound, or one that skips the lower-bound check, would forward these accesses to the wrong local address without a rebase. It repeats a set-window to an unchanged base, so a design that skips the equality test shows up with a spurious base write. It also accesses after reset and after an invalidate, so a design that treated the all-ones value as a real base would not rebase. It counts the cycles to an allocation failure exactly, so any error in the retry count or the tick spacing is seen. It also releases an index in the middle of the retries, and releases a reserved index, so a design that ignored the release or let reserved indices into the free set would grant or fail wrongly.

// File: rtl/ax_pkg.sv
package ax_pkg;
    typedef enum logic [1:0] {
        ACC_IDLE,
        ACC_CHECK,
        ACC_REBASE,
        ACC_ISSUE
    } acc_state_e;

    typedef enum logic [2:0] {
        ALC_IDLE,
        ALC_TRY,
        ALC_WAIT,
        ALC_GRANT,
        ALC_FAIL
    } alc_state_e;
endpackage

// File: rtl/ax_win_table.sv
module ax_win_table #(
    parameter int ADDR_W    = 32,
    parameter int NUM_WIN   = 16,
    parameter int WIN_BYTES = 4096
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          inval_i,
    input  logic [$clog2(NUM_WIN)-1:0]    rd_idx_i,
    input  logic [ADDR_W-1:0]             tgt_i,
    output logic                          valid_o,
    output logic                          hit_o,
    output logic [ADDR_W-1:0]             bb_o,
    output logic [$clog2(WIN_BYTES)-1:0]  off_o,
    input  logic                          wr_en_i,
    input  logic [$clog2(NUM_WIN)-1:0]    wr_idx_i,
    input  logic [ADDR_W-1:0]             wr_dw_i
);
    localparam int IDX_W = $clog2(NUM_WIN);
    localparam int OFF_W = $clog2(WIN_BYTES);
    localparam logic [ADDR_W-1:0] INVALID = '1;

    logic [ADDR_W-1:0] base_q [NUM_WIN];
    logic [ADDR_W-1:0] sel;
    logic [ADDR_W-1:0] diff;

    // Base registers; invalidate wins over a same-cycle write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_WIN; i++) base_q[i] <= INVALID;
        end else if (inval_i) begin
            for (int i = 0; i < NUM_WIN; i++) base_q[i] <= INVALID;
        end else if (wr_en_i) begin
            for (int i = 0; i < NUM_WIN; i++)
                if (wr_idx_i == IDX_W'(i)) base_q[i] <= wr_dw_i;
        end
    end

    // Lookup: dword base -> byte base, range test
    always_comb begin
        sel     = base_q[rd_idx_i];
        valid_o = (sel != INVALID);
        bb_o    = {sel[ADDR_W-3:0], 2'b00};
        diff    = tgt_i - bb_o;
        hit_o   = valid_o && (tgt_i >= bb_o) && (diff < ADDR_W'(WIN_BYTES));
        off_o   = diff[OFF_W-1:0];
    end
endmodule

// File: rtl/ax_access_fsm.sv
module ax_access_fsm
    import ax_pkg::*;
#(
    parameter int              ADDR_W      = 32,
    parameter int              NUM_WIN     = 16,
    parameter int              WIN_BYTES   = 4096,
    parameter logic [ADDR_W-1:0] REGION_BASE = '0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_i,
    input  logic                          setwin_i,
    input  logic [$clog2(NUM_WIN)-1:0]    win_i,
    input  logic [ADDR_W-1:0]             addr_i,
    input  logic                          we_i,
    input  logic [31:0]                   wdata_i,
    output logic [$clog2(NUM_WIN)-1:0]    lk_idx_o,
    output logic [ADDR_W-1:0]             lk_tgt_o,
    input  logic                          valid_i,
    input  logic                          hit_i,
    input  logic [ADDR_W-1:0]             bb_i,
    input  logic [$clog2(WIN_BYTES)-1:0]  off_i,
    output logic                          wr_en_o,
    output logic [$clog2(NUM_WIN)-1:0]    wr_idx_o,
    output logic [ADDR_W-1:0]             wr_dw_o,
    output logic                          busy_o,
    output logic                          done_o,
    output logic                          bus_valid_o,
    output logic                          bus_we_o,
    output logic [ADDR_W-1:0]             bus_addr_o,
    output logic [31:0]                   bus_wdata_o
);
    localparam int IDX_W = $clog2(NUM_WIN);
    localparam int OFF_W = $clog2(WIN_BYTES);

    acc_state_e         state_q, state_d;
    logic [IDX_W-1:0]   win_q;
    logic [ADDR_W-1:0]  addr_q;
    logic               we_q;
    logic               set_q;
    logic [31:0]        wdata_q;
    logic [OFF_W-1:0]   off_q;
    logic               need_rb;

    assign lk_idx_o = win_q;
    assign lk_tgt_o = addr_q;
    assign need_rb  = set_q ? !(valid_i && (addr_q == bb_i)) : !hit_i;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ACC_IDLE;
        else        state_q <= state_d;
    end

    // Request and offset registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q   <= '0;
            addr_q  <= '0;
            we_q    <= 1'b0;
            set_q   <= 1'b0;
            wdata_q <= '0;
            off_q   <= '0;
        end else begin
            if (state_q == ACC_IDLE && req_i) begin
                win_q   <= win_i;
                addr_q  <= addr_i;
                we_q    <= we_i;
                set_q   <= setwin_i;
                wdata_q <= wdata_i;
            end
            if (state_q == ACC_CHECK) off_q <= need_rb ? '0 : off_i;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACC_IDLE:   if (req_i) state_d = ACC_CHECK;
            ACC_CHECK:  state_d = need_rb ? ACC_REBASE : ACC_ISSUE;
            ACC_REBASE: state_d = ACC_ISSUE;
            ACC_ISSUE:  state_d = ACC_IDLE;
            default:    state_d = ACC_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy_o      = (state_q != ACC_IDLE);
        done_o      = (state_q == ACC_ISSUE);
        bus_valid_o = (state_q == ACC_ISSUE) && !set_q;
        bus_we_o    = we_q;
        bus_wdata_o = wdata_q;
        bus_addr_o  = REGION_BASE + ADDR_W'({win_q, off_q});
        wr_en_o     = (state_q == ACC_REBASE);
        wr_idx_o    = win_q;
        wr_dw_o     = {2'b00, addr_q[ADDR_W-1:2]};
    end
endmodule

// File: rtl/ax_pool.sv
module ax_pool
    import ax_pkg::*;
#(
    parameter int NUM_WIN   = 16,
    parameter int NUM_RSVD  = 4,
    parameter int RETRY_MAX = 1000,
    parameter int TICK_CYC  = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rsv_req_i,
    input  logic [$clog2(NUM_WIN)-1:0]  rsv_idx_i,
    output logic                        rsv_ok_o,
    output logic                        rsv_rej_o,
    output logic [$clog2(NUM_WIN)-1:0]  rsv_win_o,
    input  logic                        alloc_req_i,
    output logic                        alloc_busy_o,
    output logic                        alloc_ok_o,
    output logic                        alloc_fail_o,
    output logic [$clog2(NUM_WIN)-1:0]  alloc_win_o,
    input  logic                        rel_i,
    input  logic [$clog2(NUM_WIN)-1:0]  rel_idx_i
);
    localparam int IDX_W = $clog2(NUM_WIN);
    localparam int TRY_W = $clog2(RETRY_MAX + 1);
    localparam int TK_W  = $clog2(TICK_CYC + 1);
    localparam logic [TRY_W-1:0] LAST_TRY = TRY_W'(RETRY_MAX - 1);
    localparam logic [TK_W-1:0]  LAST_TK  = TK_W'(TICK_CYC - 1);

    alc_state_e         state_q, state_d;
    logic [NUM_WIN-1:0] free_q, free_d;
    logic [IDX_W-1:0]   pick, win_q;
    logic [TRY_W-1:0]   tries_q;
    logic [TK_W-1:0]    tick_q;
    logic               any_free, take;
    logic               rsv_ok_q, rsv_rej_q;
    logic [IDX_W-1:0]   rsv_win_q;

    assign any_free = |free_q;
    assign take     = (state_q == ALC_TRY) && any_free;

    // Lowest free index
    always_comb begin
        pick = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--)
            if (free_q[i]) pick = IDX_W'(i);
    end

    // Free-set update: take and release may share a cycle
    always_comb begin
        free_d = free_q;
        if (take) free_d[pick] = 1'b0;
        if (rel_i && (int'(rel_idx_i) >= NUM_RSVD)) free_d[rel_idx_i] = 1'b1;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ALC_IDLE;
        else        state_q <= state_d;
    end

    // Data registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_WIN; i++) free_q[i] <= (i >= NUM_RSVD);
            win_q     <= '0;
            tries_q   <= '0;
            tick_q    <= '0;
            rsv_ok_q  <= 1'b0;
            rsv_rej_q <= 1'b0;
            rsv_win_q <= '0;
        end else begin
            free_q <= free_d;
            if (take) win_q <= pick;
            if (state_q == ALC_IDLE)                   tries_q <= '0;
            else if (state_q == ALC_TRY && !any_free)  tries_q <= tries_q + 1'b1;
            if (state_q == ALC_WAIT && tick_q != LAST_TK) tick_q <= tick_q + 1'b1;
            else                                          tick_q <= '0;
            rsv_ok_q  <= rsv_req_i && (int'(rsv_idx_i) < NUM_RSVD);
            rsv_rej_q <= rsv_req_i && (int'(rsv_idx_i) >= NUM_RSVD);
            if (rsv_req_i) rsv_win_q <= rsv_idx_i;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ALC_IDLE:  if (alloc_req_i) state_d = ALC_TRY;
            ALC_TRY: begin
                if (any_free)                 state_d = ALC_GRANT;
                else if (tries_q == LAST_TRY) state_d = ALC_FAIL;
                else                          state_d = ALC_WAIT;
            end
            ALC_WAIT:  if (tick_q == LAST_TK) state_d = ALC_TRY;
            ALC_GRANT: state_d = ALC_IDLE;
            ALC_FAIL:  state_d = ALC_IDLE;
            default:   state_d = ALC_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        alloc_busy_o = (state_q != ALC_IDLE);
        alloc_ok_o   = (state_q == ALC_GRANT);
        alloc_fail_o = (state_q == ALC_FAIL);
        alloc_win_o  = win_q;
        rsv_ok_o     = rsv_ok_q;
        rsv_rej_o    = rsv_rej_q;
        rsv_win_o    = rsv_win_q;
    end
endmodule

// File: rtl/aperture_xlate.sv
module aperture_xlate #(
    parameter int              ADDR_W      = 32,
    parameter int              NUM_WIN     = 16,
    parameter int              WIN_BYTES   = 4096,
    parameter int              NUM_RSVD    = 4,
    parameter int              RETRY_MAX   = 1000,
    parameter int              TICK_CYC    = 4,
    parameter logic [ADDR_W-1:0] REGION_BASE = 32'h0001_0000
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        inval_i,
    input  logic                        acc_req_i,
    input  logic                        acc_setwin_i,
    input  logic [$clog2(NUM_WIN)-1:0]  acc_win_i,
    input  logic [ADDR_W-1:0]           acc_addr_i,
    input  logic                        acc_we_i,
    input  logic [31:0]                 acc_wdata_i,
    output logic                        acc_busy_o,
    output logic                        acc_done_o,
    output logic                        bus_valid_o,
    output logic                        bus_we_o,
    output logic [ADDR_W-1:0]           bus_addr_o,
    output logic [31:0]                 bus_wdata_o,
    output logic                        cfg_wr_o,
    output logic [$clog2(NUM_WIN)-1:0]  cfg_idx_o,
    output logic [ADDR_W-1:0]           cfg_base_o,
    input  logic                        rsv_req_i,
    input  logic [$clog2(NUM_WIN)-1:0]  rsv_idx_i,
    output logic                        rsv_ok_o,
    output logic                        rsv_rej_o,
    output logic [$clog2(NUM_WIN)-1:0]  rsv_win_o,
    input  logic                        alloc_req_i,
    output logic                        alloc_busy_o,
    output logic                        alloc_ok_o,
    output logic                        alloc_fail_o,
    output logic [$clog2(NUM_WIN)-1:0]  alloc_win_o,
    input  logic                        rel_i,
    input  logic [$clog2(NUM_WIN)-1:0]  rel_idx_i
);
    localparam int IDX_W = $clog2(NUM_WIN);
    localparam int OFF_W = $clog2(WIN_BYTES);

    logic [IDX_W-1:0]  lk_idx;
    logic [ADDR_W-1:0] lk_tgt;
    logic              lk_valid, lk_hit;
    logic [ADDR_W-1:0] lk_bb;
    logic [OFF_W-1:0]  lk_off;

    ax_win_table #(
        .ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN), .WIN_BYTES(WIN_BYTES)
    ) u_table (
        .clk(clk), .rst_n(rst_n), .inval_i(inval_i),
        .rd_idx_i(lk_idx), .tgt_i(lk_tgt),
        .valid_o(lk_valid), .hit_o(lk_hit), .bb_o(lk_bb), .off_o(lk_off),
        .wr_en_i(cfg_wr_o), .wr_idx_i(cfg_idx_o), .wr_dw_i(cfg_base_o)
    );

    ax_access_fsm #(
        .ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN), .WIN_BYTES(WIN_BYTES),
        .REGION_BASE(REGION_BASE)
    ) u_access (
        .clk(clk), .rst_n(rst_n),
        .req_i(acc_req_i), .setwin_i(acc_setwin_i), .win_i(acc_win_i),
        .addr_i(acc_addr_i), .we_i(acc_we_i), .wdata_i(acc_wdata_i),
        .lk_idx_o(lk_idx), .lk_tgt_o(lk_tgt),
        .valid_i(lk_valid), .hit_i(lk_hit), .bb_i(lk_bb), .off_i(lk_off),
        .wr_en_o(cfg_wr_o), .wr_idx_o(cfg_idx_o), .wr_dw_o(cfg_base_o),
        .busy_o(acc_busy_o), .done_o(acc_done_o),
        .bus_valid_o(bus_valid_o), .bus_we_o(bus_we_o),
        .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o)
    );

    ax_pool #(
        .NUM_WIN(NUM_WIN), .NUM_RSVD(NUM_RSVD),
        .RETRY_MAX(RETRY_MAX), .TICK_CYC(TICK_CYC)
    ) u_pool (
        .clk(clk), .rst_n(rst_n),
        .rsv_req_i(rsv_req_i), .rsv_idx_i(rsv_idx_i),
        .rsv_ok_o(rsv_ok_o), .rsv_rej_o(rsv_rej_o), .rsv_win_o(rsv_win_o),
        .alloc_req_i(alloc_req_i), .alloc_busy_o(alloc_busy_o),
        .alloc_ok_o(alloc_ok_o), .alloc_fail_o(alloc_fail_o),
        .alloc_win_o(alloc_win_o),
        .rel_i(rel_i), .rel_idx_i(rel_idx_i)
    );
endmodule

// File: rtl/ax_chk.sv
module ax_chk #(
    parameter int NUM_RSVD = 4,
    parameter int IDX_W    = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             done,
    input logic             bus_valid,
    input logic             cfg_wr,
    input logic             alloc_ok,
    input logic             alloc_fail,
    input logic [IDX_W-1:0] alloc_win,
    input logic             rsv_req,
    input logic [IDX_W-1:0] rsv_idx,
    input logic             rsv_ok,
    input logic             rsv_rej
);
    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R5
    bus_in_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> done);
    // R3
    rebase_then_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (done && !cfg_wr));
    // R8
    alloc_not_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_ok |-> (int'(alloc_win) >= NUM_RSVD));
    // R9
    alloc_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(alloc_ok && alloc_fail));
    // R7
    rsv_rej_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsv_rej |-> (int'($past(rsv_idx)) >= NUM_RSVD));
    // R7
    rsv_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsv_ok |-> ($past(rsv_req) && !rsv_rej));
endmodule

bind aperture_xlate ax_chk #(.NUM_RSVD(NUM_RSVD), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .done(acc_done_o), .bus_valid(bus_valid_o),
    .cfg_wr(cfg_wr_o), .alloc_ok(alloc_ok_o), .alloc_fail(alloc_fail_o),
    .alloc_win(alloc_win_o), .rsv_req(rsv_req_i), .rsv_idx(rsv_idx_i),
    .rsv_ok(rsv_ok_o), .rsv_rej(rsv_rej_o)
);

// File: tb/tb_aperture_xlate.sv
`timescale 1ns/1ps
module tb_aperture_xlate;
    localparam int          AW   = 32;
    localparam int          NW   = 16;
    localparam int          WB   = 4096;
    localparam int          NR   = 4;
    localparam int          RMAX = 1000;
    localparam int          TK   = 4;
    localparam logic [31:0] RB   = 32'h0001_0000;
    localparam int          FAIL_K = (RMAX - 1) * (TK + 1) + 1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic inval_i = 0, acc_req_i = 0, acc_setwin_i = 0, acc_we_i = 0;
    logic [3:0] acc_win_i = 0, rsv_idx_i = 0, rel_idx_i = 0;
    logic [31:0] acc_addr_i = 0, acc_wdata_i = 0;
    logic rsv_req_i = 0, alloc_req_i = 0, rel_i = 0;
    logic acc_busy_o, acc_done_o, bus_valid_o, bus_we_o, cfg_wr_o;
    logic [31:0] bus_addr_o, bus_wdata_o, cfg_base_o;
    logic [3:0] cfg_idx_o, rsv_win_o, alloc_win_o;
    logic rsv_ok_o, rsv_rej_o, alloc_busy_o, alloc_ok_o, alloc_fail_o;

    int checks = 0, errors = 0;
    bit ended = 0;

    always #10 clk = ~clk;

    aperture_xlate #(.ADDR_W(AW), .NUM_WIN(NW), .WIN_BYTES(WB), .NUM_RSVD(NR),
        .RETRY_MAX(RMAX), .TICK_CYC(TK), .REGION_BASE(RB)) dut (.*);

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // One access; lat = cycles after the cycle following the accepting edge
    task automatic do_acc(input logic sw, input logic [3:0] w, input logic [31:0] a,
                          input logic we, input logic [31:0] wd,
                          output int lat, output bit saw_cfg, output logic [3:0] cidx,
                          output logic [31:0] cval, output bit bv, output bit bwe,
                          output logic [31:0] ba, output logic [31:0] bwd);
        @(negedge clk);
        acc_req_i = 1; acc_setwin_i = sw; acc_win_i = w; acc_addr_i = a;
        acc_we_i = we; acc_wdata_i = wd;
        @(posedge clk); @(negedge clk);
        acc_req_i = 0;
        lat = 0; saw_cfg = 0; cidx = 0; cval = 0; bv = 0; bwe = 0; ba = 0; bwd = 0;
        for (int n = 1; n <= 6; n++) begin
            @(posedge clk); @(negedge clk);
            if (cfg_wr_o) begin saw_cfg = 1; cidx = cfg_idx_o; cval = cfg_base_o; end
            if (acc_done_o) begin
                lat = n; bv = bus_valid_o; bwe = bus_we_o; ba = bus_addr_o; bwd = bus_wdata_o;
                break;
            end
        end
    endtask

    // Access and check the outcome in one call
    task automatic acc_chk(input string req, input logic sw, input logic [3:0] w,
                           input logic [31:0] a, input logic we, input logic [31:0] wd,
                           input bit exp_rb, input logic [31:0] exp_ba);
        int lat; bit sc, bv, bwe; logic [3:0] ci; logic [31:0] cv, ba, bwd;
        do_acc(sw, w, a, we, wd, lat, sc, ci, cv, bv, bwe, ba, bwd);
        chk(lat == (exp_rb ? 2 : 1), req, lat, exp_rb ? 2 : 1);
        chk(sc == exp_rb, req, sc, exp_rb);
        if (exp_rb) chk(ci == w && cv == (a >> 2), req, cv, a >> 2);
        chk(bv == !sw, req, bv, !sw);
        chk(ba == exp_ba, req, ba, exp_ba);
        if (!sw) chk(bwe == we && bwd == wd, req, bwd, wd);
    endtask

    task automatic do_alloc(output bit ok, output bit fl, output logic [3:0] w, output int k,
                            input int rel_at, input logic [3:0] rel_w);
        @(negedge clk); alloc_req_i = 1;
        @(posedge clk); @(negedge clk); alloc_req_i = 0;
        ok = 0; fl = 0; w = 0; k = 0;
        for (int n = 1; n <= FAIL_K + 20; n++) begin
            @(posedge clk); @(negedge clk);
            rel_i = 0;
            if (n == rel_at) begin rel_i = 1; rel_idx_i = rel_w; end
            if (alloc_ok_o || alloc_fail_o) begin
                ok = alloc_ok_o; fl = alloc_fail_o; w = alloc_win_o; k = n; break;
            end
        end
        rel_i = 0;
    endtask

    task automatic pulse_rel(input logic [3:0] w);
        @(negedge clk); rel_i = 1; rel_idx_i = w;
        @(negedge clk); rel_i = 0;
    endtask

    task automatic t_reset();
        chk(!acc_busy_o && !acc_done_o && !bus_valid_o && !cfg_wr_o, "R1 reset idle", acc_busy_o, 0);
        chk(!alloc_busy_o && !alloc_ok_o && !alloc_fail_o && !rsv_ok_o && !rsv_rej_o,
            "R8 reset idle", alloc_busy_o, 0);
        acc_chk("R1 first access rebases", 0, 4'd0, 32'h0000_2000, 0, 0, 1, RB);
    endtask

    task automatic t_hit();
        acc_chk("R2 R4 R5 write hit", 0, 4'd0, 32'h0000_2ABC, 1, 32'hCAFE_0001, 0, RB + 32'hABC);
        acc_chk("R2 R5 read hit",     0, 4'd0, 32'h0000_2010, 0, 32'h0, 0, RB + 32'h10);
    endtask

    task automatic t_edges();
        acc_chk("R2 last byte hit",    0, 4'd0, 32'h0000_2FFF, 0, 0, 0, RB + 32'hFFF);
        acc_chk("R3 one past window",  0, 4'd0, 32'h0000_3000, 1, 32'h55, 1, RB);
        acc_chk("R3 below base",       0, 4'd0, 32'h0000_2FFC, 0, 0, 1, RB);
    endtask

    task automatic t_other_win();
        acc_chk("R3 R4 window 5 miss", 0, 4'd5, 32'h1234_5678, 1, 32'h77, 1, RB + 32'h5000);
        acc_chk("R4 window 5 hit",     0, 4'd5, 32'h1234_5FF0, 0, 0, 0, RB + 32'h5978);
    endtask

    task automatic t_setwin();
        acc_chk("R6 setwin new base",  1, 4'd7, 32'h0000_4000, 0, 0, 1, RB + 32'h7000);
        acc_chk("R6 setwin same base", 1, 4'd7, 32'h0000_4000, 0, 0, 0, RB + 32'h7000);
        acc_chk("R6 R4 access after setwin", 0, 4'd7, 32'h0000_4010, 0, 0, 0, RB + 32'h7010);
    endtask

    task automatic t_inval();
        @(negedge clk); inval_i = 1;
        @(negedge clk); inval_i = 0;
        acc_chk("R11 miss after invalidate", 0, 4'd7, 32'h0000_4010, 0, 0, 1, RB + 32'h7000);
        acc_chk("R11 window 0 also invalid", 0, 4'd0, 32'h0000_2FFC, 0, 0, 1, RB);
    endtask

    task automatic t_reserved();
        logic [3:0] idxs [3] = '{4'd2, 4'd4, 4'd15};
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); rsv_req_i = 1; rsv_idx_i = idxs[i];
            @(negedge clk); rsv_req_i = 0;
            if (idxs[i] < NR)
                chk(rsv_ok_o && !rsv_rej_o && rsv_win_o == idxs[i], "R7 reserved grant", rsv_win_o, idxs[i]);
            else
                chk(rsv_rej_o && !rsv_ok_o, "R7 reserved reject", rsv_ok_o, 0);
        end
    endtask

    task automatic t_alloc_order();
        bit ok, fl; logic [3:0] w; int k;
        for (int e = NR; e < NW; e++) begin
            do_alloc(ok, fl, w, k, 0, 0);
            chk(ok && !fl && w == 4'(e) && k == 1, "R8 lowest free grant", w, e);
        end
    endtask

    task automatic t_alloc_empty();
        bit ok, fl; logic [3:0] w; int k;
        do_alloc(ok, fl, w, k, 0, 0);
        chk(fl && !ok, "R9 empty fails", ok, 0);
        chk(k == FAIL_K, "R9 retry timing", k, FAIL_K);
    endtask

    task automatic t_release();
        bit ok, fl; logic [3:0] w; int k;
        pulse_rel(4'd9);
        do_alloc(ok, fl, w, k, 0, 0);
        chk(ok && w == 4'd9 && k == 1, "R10 released index granted", w, 9);
        pulse_rel(4'd2);
        do_alloc(ok, fl, w, k, 0, 0);
        chk(fl && !ok && k == FAIL_K, "R10 reserved release ignored", k, FAIL_K);
        do_alloc(ok, fl, w, k, 100, 4'd11);
        chk(ok && w == 4'd11, "R10 release during retry", w, 11);
        chk(k == (100 / (TK + 1) + 1) * (TK + 1) + 1, "R10 R9 next attempt grants", k,
            (100 / (TK + 1) + 1) * (TK + 1) + 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_hit();
        t_edges();
        t_other_win();
        t_setwin();
        t_inval();
        t_reserved();
        t_alloc_order();
        t_alloc_empty();
        t_release();
        repeat (3) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        finish_run();
    end
endmodule